// File: doc/BRIEF.md
# Host Bridge Memory Routing Registers

This block is the slice of a host bridge's configuration space that steers the legacy low-memory map. It stores seven shadow-attribute bytes and one SMRAM control byte, decodes them into read-enable and write-enable controls for thirteen shadow regions, and produces two SMRAM flags. The first flag says whether the SMRAM area is visible to ordinary accesses. The second says whether the SMM-side mapping is enabled. The address decoder downstream consumes these controls. Region 0 is the system BIOS area. Regions 1 to 12 are equal expansion-ROM windows at ascending addresses.

Software reaches the registers through a dword-addressed configuration port with four byte enables, so a 1-, 2- or 4-byte access touches only the bytes it names. The slice also returns fixed identification bytes and a read-only byte that reports total memory size. It raises a one-cycle remap request whenever a write lands on any routing byte, which tells the decoder to re-evaluate its windows.

Top module: `hbr_mem_route`

## Requirements
- R1: After reset every attribute byte is 0, so all 13 region read and write enables are 0. The SMRAM byte (offset 0x72, dword 0x1C lane 2) reads 0x02, which gives smram_pci_vis=1 and smram_smm_en=0. remap_req is 0.
- R2: Region i takes its 2-bit field from the attribute byte at offset 0x59+ceil(i/2). Region 0 uses bits [5:4] of 0x59. Odd regions use bits [1:0] and even regions above 0 use bits [5:4]. In each field, bit 0 is read-enable and bit 1 is write-enable.
- R3: A write updates only the bytes whose enable is set (lane b of dword d is offset 4d+b). A write with all enables clear changes nothing.
- R4: Reserved bits read zero. These are bits [7:6] and [3:2] of 0x5A–0x5F, bits [7:6] and [3:0] of 0x59, bit 7 of the SMRAM byte, and every unimplemented offset, 0x58 included.
- R5: smram_pci_vis is 1 exactly when SMRAM bit 6 (open) is 0. smram_smm_en is 1 exactly when SMRAM bit 3 (global enable) is 1.
- R6: SMRAM bit 4 (lock) is stored and read back, but has no locking effect: later writes still update the SMRAM byte.
- R7: remap_req is high for one cycle after any write whose enabled bytes include an offset in 0x59–0x5F or offset 0x72. Other writes leave it low.
- R8: Offset 0x57 (dword 0x15 lane 3) reads min(floor(mem_total_mib/8), 255) and ignores writes.
- R9: Dword 0 reads {DEVICE_ID, VENDOR_ID}. Dword 2 reads 0x06000002, which is class code 0x060000 (host bridge) and revision 0x02.
- R10: Region and SMRAM outputs take their new values in the cycle after the write and stay unchanged in cycles that follow no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw_addr | input | 6 | Dword index (byte offset >> 2) |
| cfg_be | input | 4 | Byte enables, lane b = offset 4d+b |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the addressed dword (combinational) |
| mem_total_mib | input | MIB_W | Static total memory size in MiB |
| shd_rd_en | output | 13 | Per-region read enable |
| shd_wr_en | output | 13 | Per-region write enable |
| smram_pci_vis | output | 1 | SMRAM area shows bus space to normal accesses |
| smram_smm_en | output | 1 | SMM-side SMRAM mapping enabled |
| remap_req | output | 1 | One-cycle remap request |

## Verification
The assertions check the following on every cycle. A remap request always follows a write. Routing outputs never move without a remap request, and they hold still after any cycle with no write. A write to a locked SMRAM byte still lands. The scenarios alone can show the values themselves: the field each region draws from, the masking of reserved bits, partial and empty byte-enable writes, the clamped size byte and the identification dwords.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
    localparam int NUM_REGIONS = 13;
    localparam int ATTR_BYTES  = (NUM_REGIONS + 2) / 2;

    localparam logic [7:0] ATTR_BASE = 8'h59;
    localparam logic [7:0] SMRAM_OFS = 8'h72;
    localparam logic [7:0] MEMSZ_OFS = 8'h57;

    localparam logic [7:0] ATTR_MASK_FIRST = 8'h30;
    localparam logic [7:0] ATTR_MASK_PAIR  = 8'h33;
    localparam logic [7:0] SMRAM_RESET     = 8'h02;
    localparam logic [7:0] SMRAM_MASK      = 8'h7F;

    localparam int SM_OPEN_BIT   = 6;
    localparam int SM_LOCK_BIT   = 4;
    localparam int SM_ENABLE_BIT = 3;

    localparam logic [23:0] CLASS_CODE = 24'h060000;
    localparam logic [7:0]  REVISION   = 8'h02;

    typedef logic [ATTR_BYTES-1:0][7:0] attr_bank_t;

    typedef struct packed {
        attr_bank_t attr;
        logic [7:0] smram;
        logic       remap;
    } route_state_t;

    function automatic int unsigned region_byte(input int unsigned idx);
        return (idx + 1) / 2;
    endfunction

    function automatic int unsigned region_lsb(input int unsigned idx);
        return (idx % 2 == 1) ? 0 : 4;
    endfunction
endpackage

// File: rtl/hbr_cfg_regs.sv
module hbr_cfg_regs
    import hbr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [5:0]  dw_addr,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output attr_bank_t  attr_q,
    output logic [7:0]  smram_q,
    output logic        remap_q
);
    localparam route_state_t RESET_ST = '{attr: '0, smram: SMRAM_RESET, remap: 1'b0};

    route_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.remap = 1'b0;
        for (int b = 0; b < 4; b++) begin
            logic [7:0] ofs;
            ofs = {dw_addr, 2'(b)};
            if (wr && be[b]) begin
                for (int k = 0; k < ATTR_BYTES; k++) begin
                    if (ofs == ATTR_BASE + 8'(k)) begin
                        st_d.attr[k] = wdata[8*b +: 8] &
                                       ((k == 0) ? ATTR_MASK_FIRST : ATTR_MASK_PAIR);
                        st_d.remap   = 1'b1;
                    end
                end
                if (ofs == SMRAM_OFS) begin
                    st_d.smram = wdata[8*b +: 8] & SMRAM_MASK;
                    st_d.remap = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    assign attr_q  = st_q.attr;
    assign smram_q = st_q.smram;
    assign remap_q = st_q.remap;

    // R7: a remap request is only ever the echo of a write
    a_r7_remap_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        remap_q |-> $past(wr));

    // R6: the lock bit never blocks a later SMRAM write
    a_r6_lock_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr && be[2] && dw_addr == SMRAM_OFS[7:2] && smram_q[SM_LOCK_BIT])
        |-> smram_q == ($past(wdata[23:16]) & SMRAM_MASK));
endmodule

// File: rtl/hbr_shadow_map.sv
module hbr_shadow_map
    import hbr_pkg::*;
(
    input  attr_bank_t             attr,
    output logic [NUM_REGIONS-1:0] rd_en,
    output logic [NUM_REGIONS-1:0] wr_en
);
    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
        localparam int BYTE_IDX = region_byte(i);
        localparam int FIELD_LO = region_lsb(i);
        assign rd_en[i] = attr[BYTE_IDX][FIELD_LO];
        assign wr_en[i] = attr[BYTE_IDX][FIELD_LO + 1];
    end
endmodule

// File: rtl/hbr_smram_gate.sv
module hbr_smram_gate
    import hbr_pkg::*;
(
    input  logic [7:0] smram,
    output logic       pci_vis,
    output logic       smm_en
);
    assign pci_vis = ~smram[SM_OPEN_BIT];
    assign smm_en  = smram[SM_ENABLE_BIT];
endmodule

// File: rtl/hbr_cfg_readback.sv
module hbr_cfg_readback
    import hbr_pkg::*;
#(
    parameter int          MIB_W     = 16,
    parameter logic [15:0] VENDOR_ID = 16'hC0DE,
    parameter logic [15:0] DEVICE_ID = 16'h0F10
) (
    input  logic [5:0]       dw_addr,
    input  attr_bank_t       attr,
    input  logic [7:0]       smram,
    input  logic [MIB_W-1:0] mem_mib,
    output logic [31:0]      rdata
);
    localparam int UNIT_W = MIB_W - 3;

    logic [UNIT_W-1:0] units;
    logic [7:0]        size_byte;

    assign units     = mem_mib[MIB_W-1:3];
    assign size_byte = (units > UNIT_W'(255)) ? 8'hFF : units[7:0];

    always_comb begin
        for (int b = 0; b < 4; b++) begin
            logic [7:0] ofs;
            logic [7:0] val;
            ofs = {dw_addr, 2'(b)};
            val = 8'h00;
            case (ofs)
                8'h00: val = VENDOR_ID[7:0];
                8'h01: val = VENDOR_ID[15:8];
                8'h02: val = DEVICE_ID[7:0];
                8'h03: val = DEVICE_ID[15:8];
                8'h08: val = REVISION;
                8'h09: val = CLASS_CODE[7:0];
                8'h0A: val = CLASS_CODE[15:8];
                8'h0B: val = CLASS_CODE[23:16];
                default: val = 8'h00;
            endcase
            if (ofs == MEMSZ_OFS) val = size_byte;
            if (ofs == SMRAM_OFS) val = smram;
            for (int k = 0; k < ATTR_BYTES; k++)
                if (ofs == ATTR_BASE + 8'(k)) val = attr[k];
            rdata[8*b +: 8] = val;
        end
    end
endmodule

// File: rtl/hbr_mem_route.sv
module hbr_mem_route
    import hbr_pkg::*;
#(
    parameter int          MIB_W     = 16,
    parameter logic [15:0] VENDOR_ID = 16'hC0DE,
    parameter logic [15:0] DEVICE_ID = 16'h0F10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr,
    input  logic [5:0]             cfg_dw_addr,
    input  logic [3:0]             cfg_be,
    input  logic [31:0]            cfg_wdata,
    output logic [31:0]            cfg_rdata,
    input  logic [MIB_W-1:0]       mem_total_mib,
    output logic [NUM_REGIONS-1:0] shd_rd_en,
    output logic [NUM_REGIONS-1:0] shd_wr_en,
    output logic                   smram_pci_vis,
    output logic                   smram_smm_en,
    output logic                   remap_req
);
    attr_bank_t attr_q;
    logic [7:0] smram_q;

    hbr_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .dw_addr (cfg_dw_addr),
        .be      (cfg_be),
        .wdata   (cfg_wdata),
        .attr_q  (attr_q),
        .smram_q (smram_q),
        .remap_q (remap_req)
    );

    hbr_shadow_map u_map (
        .attr  (attr_q),
        .rd_en (shd_rd_en),
        .wr_en (shd_wr_en)
    );

    hbr_smram_gate u_smram (
        .smram   (smram_q),
        .pci_vis (smram_pci_vis),
        .smm_en  (smram_smm_en)
    );

    hbr_cfg_readback #(
        .MIB_W     (MIB_W),
        .VENDOR_ID (VENDOR_ID),
        .DEVICE_ID (DEVICE_ID)
    ) u_rd (
        .dw_addr (cfg_dw_addr),
        .attr    (attr_q),
        .smram   (smram_q),
        .mem_mib (mem_total_mib),
        .rdata   (cfg_rdata)
    );

    // R10: routing outputs hold after a cycle without a write
    a_r10_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_wr) |-> ($stable(shd_rd_en) && $stable(shd_wr_en) &&
                            $stable(smram_pci_vis) && $stable(smram_smm_en)));

    // R7: any change of a routing output comes with a remap request
    a_r7_change_has_remap: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(shd_rd_en) || !$stable(shd_wr_en) ||
         !$stable(smram_pci_vis) || !$stable(smram_smm_en)) |-> remap_req);
endmodule

// File: tb/hbr_mem_route_bench.sv
module hbr_mem_route_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_dw_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [15:0] mem_total_mib = 16'd512;
    logic [NREG-1:0] shd_rd_en, shd_wr_en;
    logic        smram_pci_vis, smram_smm_en, remap_req;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] m_attr [7];
    logic [7:0] m_smram;

    hbr_mem_route u_hbr_mem_route (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw_addr(cfg_dw_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_total_mib(mem_total_mib), .shd_rd_en(shd_rd_en), .shd_wr_en(shd_wr_en),
        .smram_pci_vis(smram_pci_vis), .smram_smm_en(smram_smm_en), .remap_req(remap_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [NREG-1:0] exp_en(input int bitsel);
        logic [NREG-1:0] v;
        for (int i = 0; i < NREG; i++) begin
            int lsb;
            lsb = (i % 2 == 1) ? 0 : 4;
            v[i] = m_attr[(i + 1) / 2][lsb + bitsel];
        end
        return v;
    endfunction

    // R3/R4: model of a byte-enabled write; returns whether a remap is due (R7)
    function automatic bit model_write(input int dw, input logic [3:0] be, input logic [31:0] d);
        bit hit;
        hit = 1'b0;
        for (int b = 0; b < 4; b++) begin
            int ofs;
            ofs = dw * 4 + b;
            if (be[b]) begin
                if (ofs >= 'h59 && ofs <= 'h5F) begin
                    m_attr[ofs - 'h59] = d[8*b +: 8] & ((ofs == 'h59) ? 8'h30 : 8'h33);
                    hit = 1'b1;
                end
                if (ofs == 'h72) begin
                    m_smram = d[8*b +: 8] & 8'h7F;
                    hit = 1'b1;
                end
            end
        end
        return hit;
    endfunction

    task automatic check_outputs(input string req);
        check({req, " rd_en"}, 32'(shd_rd_en), 32'(exp_en(0)));
        check({req, " wr_en"}, 32'(shd_wr_en), 32'(exp_en(1)));
        check({req, " pci_vis"}, 32'(smram_pci_vis), 32'(!m_smram[6]));
        check({req, " smm_en"}, 32'(smram_smm_en), 32'(m_smram[3]));
    endtask

    // Drive a write at a falling edge; check remap and outputs one cycle later (R10)
    task automatic cfg_write(input string req, input int dw, input logic [3:0] be,
                             input logic [31:0] d);
        bit hit;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dw_addr = 6'(dw); cfg_be = be; cfg_wdata = d;
        hit = model_write(dw, be, d);
        @(negedge clk);
        cfg_wr = 1'b0;
        check({req, " R7 remap"}, 32'(remap_req), 32'(hit));
        check_outputs({req, " R10"});
        @(negedge clk);
        check({req, " R7 remap one cycle"}, 32'(remap_req), 32'h0);
    endtask

    task automatic read_check(input string req, input int dw, input logic [31:0] exp);
        @(negedge clk);
        cfg_dw_addr = 6'(dw);
        #1;
        check(req, cfg_rdata, exp);
    endtask

    task automatic t_reset;
        check_outputs("R1 reset");
        check("R1 remap at reset", 32'(remap_req), 32'h0);
        read_check("R1 smram reset", 'h1C, 32'h0002_0000);
        read_check("R1 attr reset", 'h16, 32'h0);
    endtask

    task automatic t_ident;
        read_check("R9 vendor/device", 'h00, 32'h0F10_C0DE);
        read_check("R9 class/revision", 'h02, 32'h0600_0002);
        read_check("R4 unimplemented dword", 'h10, 32'h0);
    endtask

    task automatic t_region_map;
        cfg_write("R2 all-ones low dword", 'h16, 4'b1110, 32'hFFFF_FFFF);
        read_check("R4 reserved masked 0x58-0x5B", 'h16, 32'h3333_3000);
        cfg_write("R2 pattern high dword", 'h17, 4'b1111, 32'h0320_3112);
        read_check("R4 reserved masked 0x5C-0x5F", 'h17, 32'h0320_3112 & 32'h3333_3333);
        cfg_write("R2 pattern low dword", 'h16, 4'b1110, 32'h1302_2100);
        read_check("R2 readback low", 'h16, 32'h1302_2000);
    endtask

    task automatic t_byte_enables;
        cfg_write("R3 single byte 0x5A", 'h16, 4'b0100, 32'hFFFF_FFFF);
        read_check("R3 only 0x5A changed", 'h16, 32'h1333_2000);
        cfg_write("R3 empty enables", 'h17, 4'b0000, 32'hFFFF_FFFF);
        read_check("R3 empty enables no change", 'h17, 32'h0320_3112 & 32'h3333_3333);
        cfg_write("R7 unrelated dword", 'h10, 4'b1111, 32'hFFFF_FFFF);
        cfg_write("R7 top byte 0x5F", 'h17, 4'b1000, 32'h0100_0000);
        cfg_write("R7 smram dword other lanes", 'h1C, 4'b1011, 32'hFFFF_FFFF);
        read_check("R4 smram dword other lanes", 'h1C, 32'h0002_0000);
    endtask

    task automatic t_smram;
        cfg_write("R5 open set", 'h1C, 4'b0100, 32'h0040_0000);
        cfg_write("R5 global enable", 'h1C, 4'b0100, 32'h0008_0000);
        cfg_write("R6 lock with open+enable", 'h1C, 4'b0100, 32'h0058_0000);
        read_check("R6 lock stored", 'h1C, 32'h0058_0000);
        cfg_write("R6 write after lock", 'h1C, 4'b0100, 32'h0000_0000);
        read_check("R6 write after lock lands", 'h1C, 32'h0);
        cfg_write("R4 smram bit7", 'h1C, 4'b0100, 32'h00FF_0000);
        read_check("R4 smram bit7 reads zero", 'h1C, 32'h007F_0000);
    endtask

    task automatic t_memsize;
        mem_total_mib = 16'd512;
        read_check("R8 512 MiB", 'h15, 32'h4000_0000);
        mem_total_mib = 16'd7;
        read_check("R8 7 MiB", 'h15, 32'h0);
        mem_total_mib = 16'd2047;
        read_check("R8 2047 MiB", 'h15, 32'hFF00_0000);
        mem_total_mib = 16'd4096;
        read_check("R8 clamp", 'h15, 32'hFF00_0000);
        mem_total_mib = 16'd1000;
        cfg_write("R8 write ignored", 'h15, 4'b1000, 32'h0100_0000);
        read_check("R8 after write", 'h15, 32'h7D00_0000);
    endtask

    initial begin
        for (int k = 0; k < 7; k++) m_attr[k] = 8'h00;
        m_smram = 8'h02;
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        t_ident();
        t_region_map();
        t_byte_enables();
        t_smram();
        t_memsize();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule